// File: doc/BRIEF.md
# Digital Potentiometer Command Executor

This block runs the command layer of a four-channel digital potentiometer. It sits behind a serial bus front end. That front end detects START and STOP, matches the device address and hands over the received bytes one at a time. The executor decodes the byte that follows the address, which holds an opcode, a pot select and a register select. It then acts on a register bank. Each pot has one 8-bit wiper counter register (WCR) and four 8-bit data registers, and the data registers stand in for nonvolatile cells.

Register changes requested in a frame are held as pending and take effect only at STOP. A change that writes a data register starts a write-cycle timer. While that timer runs, the block reports busy and ignores all frames, so the front end can withhold acknowledge for polling. Read commands place the selected register byte on an output for the front end to send as the third byte. An increment/decrement command lets the front end move the selected wiper one tap per step pulse until STOP.

Top module: `dpot_exec`

## Requirements
- R1: After reset, data register r of pot p holds DR_SEED + 4*p + r (mod 256), and each WCR equals its pot's data register 0. Busy is low.
- R2: The command byte is decoded as opcode in bits 7:4, pot select in bits 3:2 and register select in bits 1:0. Opcode 1001 presents WCR[pot] on rd_data and opcode 1011 presents DR[pot][reg], with rd_valid high, in the cycle after the command byte is accepted.
- R3: Opcode 1010 followed by a data byte loads that byte into WCR[pot] at STOP and not earlier, and does not raise busy.
- R4: Opcode 1100 followed by a data byte loads DR[pot][reg] at STOP. Busy is then high for exactly WR_CYCLES clock cycles, starting in the cycle after STOP.
- R5: Opcode 1101 copies DR[pot][reg] into WCR[pot] at STOP with no data byte and no busy period.
- R6: Opcode 1110 copies WCR[pot] into DR[pot][reg] at STOP with no data byte and a busy period of WR_CYCLES.
- R7: Opcode 0001 copies DR[p][reg] into WCR[p] for all four pots at STOP, whatever the pot select bits hold.
- R8: Opcode 1000 copies WCR[p] into DR[p][reg] for all four pots at STOP, whatever the pot select bits hold, followed by a busy period of WR_CYCLES.
- R9: After opcode 0010, each step pulse with step_up=1 raises bits 5:0 of WCR[pot] by one, stopping at 63. With step_up=0 it lowers them by one, stopping at 0. Bits 7:6 are kept. Each step shows on wcr_flat in the next cycle.
- R10: While busy is high, byte_ready is low and frame_start, bytes and STOP have no effect on any register.
- R11: An unknown opcode is accepted and changes no register. A write frame that ends at STOP before its data byte arrives changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; performs the power-up recall |
| frame_start | input | 1 | Pulse: START plus address match seen by the front end |
| byte_valid | input | 1 | Pulse: byte_data holds a received byte |
| byte_data | input | 8 | Received byte |
| byte_ready | output | 1 | Executor accepts bytes (low while busy) |
| stop | input | 1 | Pulse: STOP seen on the bus |
| step_pulse | input | 1 | One wiper step request while in increment/decrement mode |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| rd_data | output | 8 | Register byte for the front end to transmit |
| rd_valid | output | 1 | rd_data holds a read result for the current frame |
| busy | output | 1 | Emulated nonvolatile write cycle in progress |
| wcr_flat | output | 32 | All four WCRs, pot p in bits 8p+7:8p |

## Verification
On every cycle, the assertions check the following. Wiper registers move only in the cycle after a STOP or a step pulse. Busy rises only straight after a STOP and never lasts longer than the write-cycle count. The wipers stay frozen throughout a busy period, and no read result stays presented once busy is high. What the bench's sweeps alone can show is the arithmetic of each command: the reset recall pattern, the exact pot and register that every opcode touches, the global copies across all pots, the saturation points of stepping, and the absence of change after unknown or cut-short frames. The bench reads the register bank back through read commands and the wiper output.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    parameter int NPOTS  = 4;
    parameter int NREGS  = 4;
    parameter int DW     = 8;
    parameter int POS_W  = 6;
    localparam int PSEL_W = $clog2(NPOTS);
    localparam int RSEL_W = $clog2(NREGS);
    localparam int OPC_W  = 4;
    localparam int OPC_LSB = DW - OPC_W;

    localparam logic [OPC_W-1:0] OPC_RD_WCR  = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_WR_WCR  = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_RD_DR   = 4'b1011;
    localparam logic [OPC_W-1:0] OPC_WR_DR   = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_DR2W    = 4'b1101;
    localparam logic [OPC_W-1:0] OPC_W2DR    = 4'b1110;
    localparam logic [OPC_W-1:0] OPC_G_DR2W  = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_G_W2DR  = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_STEP    = 4'b0010;

    typedef enum logic [3:0] {
        K_NONE, K_RD_WCR, K_WR_WCR, K_RD_DR, K_WR_DR,
        K_DR2W, K_W2DR, K_G_DR2W, K_G_W2DR, K_STEP
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_DATA, ST_DONE, ST_STEP
    } phase_e;

    function automatic logic [DW-1:0] boot_value(int p, int r, int seed);
        int v;
        v = seed + p * NREGS + r;
        return DW'(v);
    endfunction
endpackage

// File: rtl/dpot_cmd_decode.sv
module dpot_cmd_decode
    import dpot_pkg::*;
(
    input  logic [DW-1:0]     cmd_byte,
    output kind_e             kind,
    output logic              needs_data,
    output logic [PSEL_W-1:0] pot_sel,
    output logic [RSEL_W-1:0] reg_sel
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc     = cmd_byte[OPC_LSB +: OPC_W];
        pot_sel = cmd_byte[RSEL_W +: PSEL_W];
        reg_sel = cmd_byte[0 +: RSEL_W];
        unique case (opc)
            OPC_RD_WCR: kind = K_RD_WCR;
            OPC_WR_WCR: kind = K_WR_WCR;
            OPC_RD_DR:  kind = K_RD_DR;
            OPC_WR_DR:  kind = K_WR_DR;
            OPC_DR2W:   kind = K_DR2W;
            OPC_W2DR:   kind = K_W2DR;
            OPC_G_DR2W: kind = K_G_DR2W;
            OPC_G_W2DR: kind = K_G_W2DR;
            OPC_STEP:   kind = K_STEP;
            default:    kind = K_NONE;
        endcase
        needs_data = (kind == K_WR_WCR) || (kind == K_WR_DR);
    end
endmodule

// File: rtl/dpot_wr_timer.sv
module dpot_wr_timer #(
    parameter int CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/dpot_exec.sv
module dpot_exec
    import dpot_pkg::*;
#(
    parameter int WR_CYCLES = 40,
    parameter int DR_SEED   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                byte_valid,
    input  logic [DW-1:0]       byte_data,
    output logic                byte_ready,
    input  logic                stop,
    input  logic                step_pulse,
    input  logic                step_up,
    output logic [DW-1:0]       rd_data,
    output logic                rd_valid,
    output logic                busy,
    output logic [NPOTS*DW-1:0] wcr_flat
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    typedef struct packed {
        phase_e                                st;
        kind_e                                 ckind;
        kind_e                                 pkind;
        logic [PSEL_W-1:0]                     ppot;
        logic [RSEL_W-1:0]                     preg;
        logic [DW-1:0]                         pdata;
        logic [DW-1:0]                         rd;
        logic                                  rdv;
        logic [NPOTS-1:0][DW-1:0]              wcr;
        logic [NPOTS-1:0][NREGS-1:0][DW-1:0]   dr;
    } exec_s;

    exec_s q, n;
    logic  nv_go;

    kind_e             dk;
    logic              dneed;
    logic [PSEL_W-1:0] dpot;
    logic [RSEL_W-1:0] dreg;

    dpot_cmd_decode u_dec (
        .cmd_byte   (byte_data),
        .kind       (dk),
        .needs_data (dneed),
        .pot_sel    (dpot),
        .reg_sel    (dreg)
    );

    dpot_wr_timer #(.CYC(WR_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (nv_go),
        .busy  (busy)
    );

    function automatic exec_s boot_state();
        exec_s s;
        s       = '0;
        s.st    = ST_IDLE;
        s.ckind = K_NONE;
        s.pkind = K_NONE;
        for (int p = 0; p < NPOTS; p++) begin
            for (int r = 0; r < NREGS; r++)
                s.dr[p][r] = boot_value(p, r, DR_SEED);
            s.wcr[p] = boot_value(p, 0, DR_SEED);
        end
        return s;
    endfunction

    logic [POS_W-1:0] pos;

    always_comb begin
        n     = q;
        nv_go = 1'b0;
        pos   = q.wcr[q.ppot][POS_W-1:0];

        if (q.st == ST_STEP && step_pulse) begin
            if (step_up) begin
                if (pos != POS_MAX) pos = pos + 1'b1;
            end else begin
                if (pos != '0) pos = pos - 1'b1;
            end
            n.wcr[q.ppot][POS_W-1:0] = pos;
        end

        if (busy) begin
            n.st = q.st;
        end else if (frame_start) begin
            n.st    = ST_CMD;
            n.pkind = K_NONE;
            n.rdv   = 1'b0;
        end else if (stop) begin
            if (q.st != ST_IDLE) begin
                unique case (q.pkind)
                    K_WR_WCR: n.wcr[q.ppot] = q.pdata;
                    K_WR_DR: begin
                        n.dr[q.ppot][q.preg] = q.pdata;
                        nv_go = 1'b1;
                    end
                    K_DR2W: n.wcr[q.ppot] = q.dr[q.ppot][q.preg];
                    K_W2DR: begin
                        n.dr[q.ppot][q.preg] = q.wcr[q.ppot];
                        nv_go = 1'b1;
                    end
                    K_G_DR2W: begin
                        for (int p = 0; p < NPOTS; p++)
                            n.wcr[p] = q.dr[p][q.preg];
                    end
                    K_G_W2DR: begin
                        for (int p = 0; p < NPOTS; p++)
                            n.dr[p][q.preg] = q.wcr[p];
                        nv_go = 1'b1;
                    end
                    default: n.pkind = K_NONE;
                endcase
            end
            n.st    = ST_IDLE;
            n.pkind = K_NONE;
            n.rdv   = 1'b0;
        end else if (byte_valid) begin
            unique case (q.st)
                ST_CMD: begin
                    n.ckind = dk;
                    n.ppot  = dpot;
                    n.preg  = dreg;
                    n.st    = ST_DONE;
                    if (dneed) begin
                        n.st = ST_DATA;
                    end else begin
                        unique case (dk)
                            K_RD_WCR: begin
                                n.rd  = q.wcr[dpot];
                                n.rdv = 1'b1;
                            end
                            K_RD_DR: begin
                                n.rd  = q.dr[dpot][dreg];
                                n.rdv = 1'b1;
                            end
                            K_DR2W, K_W2DR, K_G_DR2W, K_G_W2DR: n.pkind = dk;
                            K_STEP:  n.st = ST_STEP;
                            default: n.pkind = K_NONE;
                        endcase
                    end
                end
                ST_DATA: begin
                    n.pdata = byte_data;
                    n.pkind = q.ckind;
                    n.st    = ST_DONE;
                end
                default: n.st = q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= boot_state();
        else        q <= n;
    end

    assign byte_ready = !busy;
    assign rd_data    = q.rd;
    assign rd_valid   = q.rdv;
    assign wcr_flat   = q.wcr;
endmodule

// File: rtl/dpot_exec_chk.sv
module dpot_exec_chk #(
    parameter int WR_CYCLES = 40,
    parameter int WW        = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop,
    input logic          step_pulse,
    input logic          busy,
    input logic          rd_valid,
    input logic [WW-1:0] wcr_flat
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    // R3
    wcr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wcr_flat != $past(wcr_flat)) |-> ($past(stop) || $past(step_pulse)));

    // R4
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= WR_CYCLES);

    // R10
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(wcr_flat));

    // R2
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);
endmodule

bind dpot_exec dpot_exec_chk #(.WR_CYCLES(WR_CYCLES), .WW(dpot_pkg::NPOTS*dpot_pkg::DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop       (stop),
    .step_pulse (step_pulse),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .wcr_flat   (wcr_flat)
);

// File: tb/sim_dpot_exec.sv
module sim_dpot_exec;
    localparam int WR   = 12;
    localparam int SEED = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_ready;
    logic        stop = 1'b0;
    logic        step_pulse = 1'b0;
    logic        step_up = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        busy;
    logic [31:0] wcr_flat;

    int errs = 0;
    int total = 0;

    logic [7:0] m_wcr [4];
    logic [7:0] m_dr  [4][4];

    always #10 clk = ~clk;

    dpot_exec #(.WR_CYCLES(WR), .DR_SEED(SEED)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
        .stop(stop), .step_pulse(step_pulse), .step_up(step_up),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .wcr_flat(wcr_flat)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_f();
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    endtask
    task automatic send_b(input logic [7:0] b);
        byte_valid = 1'b1; byte_data = b; @(negedge clk); byte_valid = 1'b0;
    endtask
    task automatic stop_f();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask
    task automatic busy_len(output int nb);
        nb = 0;
        while (busy && nb < 10000) begin nb++; @(negedge clk); end
    endtask

    task automatic check_all(string req);
        for (int p = 0; p < 4; p++) begin
            chk(req, {24'h0, wcr_flat[p*8 +: 8]}, {24'h0, m_wcr[p]});
            start_f(); send_b({4'b1001, 2'(p), 2'b00});
            chk(req, {23'h0, rd_valid, rd_data}, {23'h0, 1'b1, m_wcr[p]});
            stop_f();
            for (int r = 0; r < 4; r++) begin
                start_f(); send_b({4'b1011, 2'(p), 2'(r)});
                chk(req, {23'h0, rd_valid, rd_data}, {23'h0, 1'b1, m_dr[p][r]});
                stop_f();
            end
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int nb;
        logic [5:0] pos;
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) m_dr[p][r] = 8'(SEED + 4*p + r);
            m_wcr[p] = m_dr[p][0];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset recall
        chk("R1 busy", {31'h0, busy}, 32'h0);
        check_all("R1");

        // R3 write WCR, deferred to STOP
        for (int p = 0; p < 4; p++) begin
            start_f(); send_b({4'b1010, 2'(p), 2'b11}); send_b(8'(8'h25 + 9*p));
            chk("R3 before stop", {24'h0, wcr_flat[p*8 +: 8]}, {24'h0, m_wcr[p]});
            stop_f();
            m_wcr[p] = 8'(8'h25 + 9*p);
            chk("R3 after stop", {24'h0, wcr_flat[p*8 +: 8]}, {24'h0, m_wcr[p]});
            chk("R3 no busy", {31'h0, busy}, 32'h0);
        end

        // R4 write every data register
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) begin
                start_f(); send_b({4'b1100, 2'(p), 2'(r)}); send_b(8'(8'hA0 ^ (p*16 + r*5)));
                stop_f();
                m_dr[p][r] = 8'(8'hA0 ^ (p*16 + r*5));
                busy_len(nb);
                chk("R4 busy length", nb, WR);
            end
        check_all("R4");

        // R10 frames ignored while busy
        start_f(); send_b(8'b1100_0100); send_b(8'h5A); stop_f();
        m_dr[1][0] = 8'h5A;
        chk("R10 byte_ready", {31'h0, byte_ready}, 32'h0);
        start_f(); send_b(8'b1010_1000); send_b(8'hEE); stop_f();
        busy_len(nb);
        chk("R10 busy length", nb, WR - 4);
        chk("R10 wcr2 kept", {24'h0, wcr_flat[23:16]}, {24'h0, m_wcr[2]});

        // R5 data register to WCR, no busy
        for (int p = 0; p < 4; p++) begin
            start_f(); send_b({4'b1101, 2'(p), 2'(3 - p)}); stop_f();
            m_wcr[p] = m_dr[p][3 - p];
            chk("R5 no busy", {31'h0, busy}, 32'h0);
        end
        check_all("R5");

        // R6 WCR to data register
        start_f(); send_b(8'b1010_1000); send_b(8'h77); stop_f();
        m_wcr[2] = 8'h77;
        start_f(); send_b(8'b1110_1001); stop_f();
        m_dr[2][1] = 8'h77;
        busy_len(nb);
        chk("R6 busy length", nb, WR);
        check_all("R6");

        // R7 global data register to WCR, pot field nonzero
        start_f(); send_b(8'b0001_1110); stop_f();
        for (int p = 0; p < 4; p++) m_wcr[p] = m_dr[p][2];
        chk("R7 no busy", {31'h0, busy}, 32'h0);
        check_all("R7");

        // R8 global WCR to data register
        for (int p = 0; p < 4; p++) begin
            start_f(); send_b({4'b1010, 2'(p), 2'b00}); send_b(8'(8'h31 + 7*p)); stop_f();
            m_wcr[p] = 8'(8'h31 + 7*p);
        end
        start_f(); send_b(8'b1000_0101); stop_f();
        for (int p = 0; p < 4; p++) m_dr[p][1] = m_wcr[p];
        busy_len(nb);
        chk("R8 busy length", nb, WR);
        check_all("R8");

        // R9 stepping with saturation, upper bits kept
        start_f(); send_b(8'b1010_0000); send_b(8'hC0 | 8'd60); stop_f();
        m_wcr[0] = 8'hC0 | 8'd60;
        start_f(); send_b(8'b0010_0000);
        pos = 6'd60;
        for (int i = 0; i < 6; i++) begin
            step_up = 1'b1; step_pulse = 1'b1; @(negedge clk); step_pulse = 1'b0;
            if (pos != 6'd63) pos = pos + 1'b1;
            chk("R9 up", {24'h0, wcr_flat[7:0]}, {24'h0, 2'b11, pos});
        end
        for (int i = 0; i < 70; i++) begin
            step_up = 1'b0; step_pulse = 1'b1; @(negedge clk); step_pulse = 1'b0;
            if (pos != 6'd0) pos = pos - 1'b1;
        end
        chk("R9 down sat", {24'h0, wcr_flat[7:0]}, {24'h0, 8'hC0});
        step_up = 1'b1; step_pulse = 1'b1; @(negedge clk); step_pulse = 1'b0;
        chk("R9 one up", {24'h0, wcr_flat[7:0]}, {24'h0, 8'hC1});
        stop_f();
        m_wcr[0] = 8'hC1;
        step_pulse = 1'b1; @(negedge clk); step_pulse = 1'b0;
        chk("R9 step after stop", {24'h0, wcr_flat[7:0]}, {24'h0, 8'hC1});

        // R11 unknown opcodes and cut-short writes
        for (int o = 0; o < 16; o++) begin
            if (o inside {1, 2, 8, 9, 10, 11, 12, 13, 14}) continue;
            start_f(); send_b({4'(o), 4'b0110}); send_b(8'hFF); stop_f();
            chk("R11 unknown no busy", {31'h0, busy}, 32'h0);
        end
        start_f(); send_b(8'b1010_0100); stop_f();
        start_f(); send_b(8'b1100_1011); stop_f();
        chk("R11 cut short no busy", {31'h0, busy}, 32'h0);
        check_all("R11");

        finish_run();
    end
endmodule